// File: doc/BRIEF.md
# Serial Flash Device-Side Front End

This block is the device side of a four-wire serial flash port. It runs on a fast system clock and treats the serial clock, chip select, data input, pause and write-protect pins as asynchronous. It synchronizes all five pins and detects serial clock edges in the system domain. A transaction opens when chip select goes low. Its first byte is an opcode. A data read adds three address bytes, and the block then streams bytes from a small internal array. A status read streams the status byte. A write-enable command arms the status write, and a write-status command updates the protect field.

The pause input (`hold_n`) freezes a transaction in place while the device stays selected. During the pause the output driver is released and the clock and data pins are ignored. When the pause ends, the transfer resumes at the same bit. The write-protect input (`wp_n`) locks the protect field of the status register against writes.

Top module: `spi_flash_front`

## Requirements
- R1: While `cs_n` is high, `miso_oe` is 0. A transaction cut short by `cs_n` rising is discarded, and the next low `cs_n` starts again at the first bit of a fresh opcode.
- R2: Input bits are taken on the rising edge of `sck`, most significant bit first. The first byte after `cs_n` falls is the opcode.
- R3: `miso` changes only in response to a falling edge of `sck`. It keeps its value across a rising edge.
- R4: Opcode 0x05 drives the status byte out, most significant bit first, starting at the falling edge after the opcode. The byte repeats for as long as clocks continue. `miso_oe` is 1 during this phase.
- R5: Opcode 0x06 sets the write-arm flag, which is status bit 1.
- R6: Opcode 0x01 with the write-arm flag clear has no effect on the status register.
- R7: Opcode 0x01 with the write-arm flag set takes one data byte. Its bits 3:2 are written to status bits 3:2, and the write-arm flag clears when that byte completes. Status bits 7:4 and 0 always read 0.
- R8: While `wp_n` is low, status bits 3:2 cannot change. A write-status command still completes and clears the write-arm flag.
- R9: Opcode 0x03 followed by a 24-bit address streams array bytes starting at index = address mod DEPTH, wrapping from DEPTH-1 back to 0. The array byte at index i is (i*37 + 0xA5) mod 256.
- R10: While `hold_n` is low and the device is selected, `miso_oe` is 0 and `sck`/`mosi` activity is ignored. When `hold_n` returns high, the transfer continues from the same bit.
- R11: An opcode other than 0x01, 0x03, 0x05 or 0x06 causes all further bits to be ignored until `cs_n` rises. `miso_oe` stays 0 and the status register is unchanged.
- R12: After reset, `miso_oe` is 0 and the status byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sck` |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host, asynchronous |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| mosi | input | 1 | Serial data into the device |
| hold_n | input | 1 | Active-low pause |
| wp_n | input | 1 | Active-low write protect for status bits 3:2 |
| miso | output | 1 | Serial data out of the device |
| miso_oe | output | 1 | Output enable for `miso`; 0 means high impedance |

## Verification
The hardest situation to reach is a pause that begins in the middle of a byte. At that point the output has already moved to the next bit and the bit counters are partly advanced. The bench opens a pause right after a chosen falling edge, both inside the address bytes and inside a streamed data byte. While the pause is open it toggles `sck` and `mosi`, then releases it and checks that the returned bytes match an unpaused read. The write-protect case needs the write-arm flag set while `wp_n` is low, so that only the protect gate can block the write.

// File: rtl/spif_pkg.sv
package spif_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [7:0] {
        OP_SET_STATUS = 8'h01,
        OP_GET_DATA   = 8'h03,
        OP_GET_STATUS = 8'h05,
        OP_ARM_WRITE  = 8'h06
    } opcode_e;

    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_ADDR,
        PH_STATUS_IN,
        PH_STATUS_OUT,
        PH_DATA_OUT,
        PH_DISCARD
    } phase_e;

    typedef struct packed {
        logic [3:0] spare;
        logic [1:0] prot;
        logic       wr_armed;
        logic       busy;
    } status_t;

    function automatic logic [BYTE_W-1:0] fill_byte(input int idx);
        int v;
        v = idx * 37 + 165;
        return BYTE_W'(v);
    endfunction

    function automatic status_t pack_status(input logic [1:0] prot, input logic armed);
        status_t s;
        s          = '0;
        s.prot     = prot;
        s.wr_armed = armed;
        return s;
    endfunction

endpackage

// File: rtl/spif_sync.sv
module spif_sync #(
    parameter int              WIDTH   = 5,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= din;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/spif_store.sv
module spif_store
    import spif_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     idx,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= fill_byte(i);
        end
    end

    assign rdata = cells[idx];

endmodule

// File: rtl/spif_engine.sv
module spif_engine
    import spif_pkg::*;
#(
    parameter int ADDR_BITS = 24,
    parameter int DEPTH     = 16,
    localparam int AW       = $clog2(DEPTH),
    localparam int CW       = $clog2(ADDR_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_s,
    input  logic              csn_s,
    input  logic              mosi_s,
    input  logic              hold_s,
    input  logic              wp_n_s,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [AW-1:0]     mem_idx,
    output logic              miso,
    output logic              miso_oe
);

    phase_e                phase;
    logic [CW-1:0]         bit_cnt;
    logic [ADDR_BITS-1:0]  rx_sh;
    logic [ADDR_BITS-1:0]  rx_next;
    logic [BYTE_W-1:0]     rx_byte;
    logic [AW-1:0]         rd_ptr;
    logic [BYTE_W-1:0]     tx_sh;
    logic [2:0]            tx_cnt;
    logic                  miso_q;
    logic                  armed;
    logic [1:0]            prot;
    logic                  sck_d;
    logic                  active;
    logic                  rise;
    logic                  fall;
    logic                  out_phase;
    status_t               stat;

    assign active    = !csn_s && hold_s;
    assign rise      = active && sck_s && !sck_d;
    assign fall      = active && !sck_s && sck_d;
    assign rx_next   = {rx_sh[ADDR_BITS-2:0], mosi_s};
    assign rx_byte   = rx_next[BYTE_W-1:0];
    assign stat      = pack_status(prot, armed);
    assign out_phase = (phase == PH_STATUS_OUT) || (phase == PH_DATA_OUT);
    assign mem_idx   = (phase == PH_ADDR) ? rx_next[AW-1:0] : rd_ptr + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) sck_d <= 1'b0;
        else     sck_d <= sck_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_OPCODE;
            bit_cnt <= '0;
            rx_sh   <= '0;
            rd_ptr  <= '0;
            tx_sh   <= '0;
            tx_cnt  <= '0;
            miso_q  <= 1'b0;
            armed   <= 1'b0;
            prot    <= '0;
        end else if (csn_s) begin
            phase   <= PH_OPCODE;
            bit_cnt <= '0;
            tx_cnt  <= '0;
        end else if (rise) begin
            rx_sh <= rx_next;
            unique case (phase)
                PH_OPCODE: begin
                    if (bit_cnt == CW'(BYTE_W - 1)) begin
                        bit_cnt <= '0;
                        tx_cnt  <= '0;
                        case (rx_byte)
                            OP_ARM_WRITE: begin
                                armed <= 1'b1;
                                phase <= PH_DISCARD;
                            end
                            OP_GET_STATUS: begin
                                tx_sh <= stat;
                                phase <= PH_STATUS_OUT;
                            end
                            OP_SET_STATUS: phase <= armed ? PH_STATUS_IN : PH_DISCARD;
                            OP_GET_DATA:   phase <= PH_ADDR;
                            default:       phase <= PH_DISCARD;
                        endcase
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                PH_ADDR: begin
                    if (bit_cnt == CW'(ADDR_BITS - 1)) begin
                        bit_cnt <= '0;
                        rd_ptr  <= rx_next[AW-1:0];
                        tx_sh   <= mem_rdata;
                        phase   <= PH_DATA_OUT;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                PH_STATUS_IN: begin
                    if (bit_cnt == CW'(BYTE_W - 1)) begin
                        bit_cnt <= '0;
                        armed   <= 1'b0;
                        if (wp_n_s) prot <= rx_byte[3:2];
                        phase   <= PH_DISCARD;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (fall && out_phase) begin
            miso_q <= tx_sh[BYTE_W-1];
            tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
            tx_cnt <= tx_cnt + 1'b1;
            if (tx_cnt == 3'd7) begin
                if (phase == PH_DATA_OUT) begin
                    tx_sh  <= mem_rdata;
                    rd_ptr <= rd_ptr + 1'b1;
                end else begin
                    tx_sh <= stat;
                end
            end
        end
    end

    assign miso    = miso_q;
    assign miso_oe = active && out_phase;

    // R3: output bit register moves only on a detected falling edge
    assert_miso_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
        !fall |=> $stable(miso_q));

    // R8: protect field frozen while write protect is asserted
    assert_prot_locked_R8: assert property (@(posedge clk) disable iff (rst)
        !wp_n_s |=> $stable(prot));

    // R7: completing the status data byte always leaves the arm flag clear
    assert_arm_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (rise && !csn_s && phase == PH_STATUS_IN && bit_cnt == CW'(BYTE_W - 1)) |=> !armed);

    // R10: pause freezes all transfer progress
    assert_hold_freezes_R10: assert property (@(posedge clk) disable iff (rst)
        (!hold_s && !csn_s) |=> ($stable(bit_cnt) && $stable(tx_cnt) && $stable(phase) && $stable(tx_sh)));

    // R1: deselect returns to the opcode start
    assert_deselect_restart_R1: assert property (@(posedge clk) disable iff (rst)
        csn_s |=> (phase == PH_OPCODE && bit_cnt == '0));

    // R11: discard phase never drives the output
    assert_discard_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DISCARD) |-> !miso_oe);

endmodule

// File: rtl/spi_flash_front.sv
module spi_flash_front
    import spif_pkg::*;
#(
    parameter int ADDR_BITS   = 24,
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    input  logic hold_n,
    input  logic wp_n,
    output logic miso,
    output logic miso_oe
);

    localparam int AW   = $clog2(DEPTH);
    localparam int NPIN = 5;
    localparam logic [NPIN-1:0] PIN_IDLE = 5'b11010;

    logic [NPIN-1:0]   pins_s;
    logic [AW-1:0]     mem_idx;
    logic [BYTE_W-1:0] mem_rdata;

    spif_sync #(
        .WIDTH  (NPIN),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({wp_n, hold_n, mosi, cs_n, sck}),
        .dout(pins_s)
    );

    spif_store #(
        .DEPTH(DEPTH)
    ) u_store (
        .clk  (clk),
        .rst  (rst),
        .idx  (mem_idx),
        .rdata(mem_rdata)
    );

    spif_engine #(
        .ADDR_BITS(ADDR_BITS),
        .DEPTH    (DEPTH)
    ) u_engine (
        .clk      (clk),
        .rst      (rst),
        .sck_s    (pins_s[0]),
        .csn_s    (pins_s[1]),
        .mosi_s   (pins_s[2]),
        .hold_s   (pins_s[3]),
        .wp_n_s   (pins_s[4]),
        .mem_rdata(mem_rdata),
        .mem_idx  (mem_idx),
        .miso     (miso),
        .miso_oe  (miso_oe)
    );

    // R1: no output drive while the synchronized select is high
    assert_oe_off_deselected_R1: assert property (@(posedge clk) disable iff (rst)
        pins_s[1] |-> !miso_oe);

endmodule

// File: tb/test_spi_flash_front.sv
module test_spi_flash_front;

    localparam int HALF  = 8;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic hold_n = 1'b1;
    logic wp_n = 1'b1;
    logic miso;
    logic miso_oe;

    int errs = 0;
    int checks = 0;
    logic glitch = 1'b0;

    always #5 clk = ~clk;

    spi_flash_front #(.DEPTH(DEPTH)) i_spi_flash_front (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .hold_n(hold_n), .wp_n(wp_n), .miso(miso), .miso_oe(miso_oe)
    );

    function automatic logic [7:0] ref_fill(input int i);
        int v;
        v = (i % DEPTH) * 37 + 165;
        return 8'(v);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic begin_frame();
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic end_frame();
        tick(HALF);
        cs_n = 1'b1;
        tick(2 * HALF);
    endtask

    task automatic do_pause();
        tick(HALF);
        hold_n = 1'b0;
        tick(HALF);
        check8("R10 oe during pause", {7'd0, miso_oe}, 8'h00);
        for (int k = 0; k < 3; k++) begin
            mosi = ~mosi;
            sck  = 1'b1;
            tick(HALF);
            sck  = 1'b0;
            tick(HALF);
        end
        hold_n = 1'b1;
        tick(HALF);
    endtask

    task automatic xfer(input logic [7:0] tx, input int pause_at, output logic [7:0] rx,
                        output logic oe_all, output logic oe_none);
        oe_all  = 1'b1;
        oe_none = 1'b1;
        for (int b = 7; b >= 0; b--) begin
            mosi = tx[b];
            tick(HALF);
            rx[b] = miso;
            if (miso_oe) oe_none = 1'b0;
            else         oe_all  = 1'b0;
            sck = 1'b1;
            tick(HALF / 2);
            if (miso !== rx[b]) glitch = 1'b1;
            tick(HALF / 2);
            sck = 1'b0;
            if (b == pause_at) do_pause();
        end
    endtask

    task automatic send(input logic [7:0] tx);
        logic [7:0] r;
        logic a, n;
        xfer(tx, -1, r, a, n);
    endtask

    task automatic read_status(output logic [7:0] st);
        logic a, n;
        begin_frame();
        send(8'h05);
        xfer(8'h00, -1, st, a, n);
        end_frame();
    endtask

    task automatic write_status(input logic [7:0] v);
        begin_frame();
        send(8'h01);
        send(v);
        end_frame();
    endtask

    task automatic arm();
        begin_frame();
        send(8'h06);
        end_frame();
    endtask

    task automatic t_reset();
        logic [7:0] st;
        check8("R12 oe after reset", {7'd0, miso_oe}, 8'h00);
        read_status(st);
        check8("R12 status after reset", st, 8'h00);
    endtask

    task automatic t_write_unarmed();
        logic [7:0] st;
        write_status(8'h0C);
        read_status(st);
        check8("R6 unarmed status write", st, 8'h00);
    endtask

    task automatic t_arm();
        logic [7:0] st;
        arm();
        read_status(st);
        check8("R5/R2 arm flag bit1 msb-first", st, 8'h02);
    endtask

    task automatic t_status_stream();
        logic [7:0] a, b, c;
        logic oa, on;
        logic all_on = 1'b1;
        begin_frame();
        send(8'h05);
        xfer(8'h00, -1, a, oa, on); all_on &= oa;
        xfer(8'hFF, -1, b, oa, on); all_on &= oa;
        xfer(8'h00, -1, c, oa, on); all_on &= oa;
        end_frame();
        check8("R4 status byte 1", a, 8'h02);
        check8("R4 status byte 2", b, 8'h02);
        check8("R4 status byte 3", c, 8'h02);
        check8("R4 oe during status", {7'd0, all_on}, 8'h01);
    endtask

    task automatic t_write_armed();
        logic [7:0] st;
        write_status(8'hFC);
        read_status(st);
        check8("R7 armed write sets bits3:2 clears arm", st, 8'h0C);
        arm();
        write_status(8'h04);
        read_status(st);
        check8("R7 second armed write", st, 8'h04);
    endtask

    task automatic t_protect();
        logic [7:0] st;
        wp_n = 1'b0;
        tick(HALF);
        arm();
        read_status(st);
        check8("R8 armed while protected", st, 8'h06);
        write_status(8'h08);
        read_status(st);
        check8("R8 protect bits held, arm cleared", st, 8'h04);
        wp_n = 1'b1;
        tick(HALF);
    endtask

    task automatic read_data(input logic [23:0] addr, input int n, input int pause_addr_byte,
                             input int pause_addr_bit, input int pause_data_bit, input string tag);
        logic [7:0] r;
        logic oa, on;
        begin_frame();
        send(8'h03);
        for (int k = 0; k < 3; k++) begin
            logic [7:0] ab;
            ab = addr[23 - 8*k -: 8];
            xfer(ab, (k == pause_addr_byte) ? pause_addr_bit : -1, r, oa, on);
        end
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, (k == 0) ? pause_data_bit : -1, r, oa, on);
            check8(tag, r, ref_fill(int'(addr % DEPTH) + k));
            check8({tag, " oe"}, {7'd0, oa}, 8'h01);
        end
        end_frame();
    endtask

    task automatic t_read();
        read_data(24'h000005, 3, -1, -1, -1, "R9 read from 5");
        read_data(24'h00000E, 4, -1, -1, -1, "R9 wrap at end");
        read_data(24'hFF0003, 1, -1, -1, -1, "R9 high address bits");
    endtask

    task automatic t_partial();
        logic [7:0] st;
        begin_frame();
        for (int b = 7; b >= 4; b--) begin
            mosi = 1'(8'h06 >> b);
            tick(HALF);
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
        end_frame();
        check8("R1 oe while deselected", {7'd0, miso_oe}, 8'h00);
        read_status(st);
        check8("R1 partial command discarded", st, 8'h04);
        arm();
        read_status(st);
        check8("R1 fresh opcode after partial", st, 8'h06);
    endtask

    task automatic t_unknown();
        logic [7:0] r, st;
        logic oa, on;
        begin_frame();
        send(8'h9F);
        xfer(8'h01, -1, r, oa, on);
        check8("R11 no drive after unknown", {7'd0, on}, 8'h01);
        xfer(8'h00, -1, r, oa, on);
        check8("R11 no drive later", {7'd0, on}, 8'h01);
        end_frame();
        read_status(st);
        check8("R11 status unchanged", st, 8'h06);
        write_status(8'h04);
        read_status(st);
        check8("R11 normal decode afterwards", st, 8'h04);
    endtask

    task automatic t_pause();
        logic [7:0] r;
        logic oa, on;
        read_data(24'h000002, 2, 1, 3, 5, "R10 read across pauses");
        begin_frame();
        send(8'h05);
        xfer(8'h00, 6, r, oa, on);
        end_frame();
        check8("R10 status across pause", r, 8'h04);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(5);
        t_reset();
        t_write_unarmed();
        t_arm();
        t_status_stream();
        t_write_armed();
        t_protect();
        t_read();
        t_partial();
        t_unknown();
        t_pause();
        check8("R3 miso stable across rising edge", {7'd0, glitch}, 8'h00);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule